// File: doc/BRIEF.md
# Scoreboard Issue Controller

This block is the central scheduler for a small out-of-order core that has no result forwarding. It owns two tables: one entry per functional unit, holding the unit's operation class, its destination and source register names, and for each source the tag of the unit that will produce it; and one tag per architectural register, naming the unit that will write it next (tag zero means the register file already holds the value). Each cycle it decides whether the instruction presented at its input may be placed into a unit, which waiting units may read their operands and start, and which finished units may write their result and give up their entry.

Five units are managed: an integer unit, a load unit, a store unit and two floating-point units. Instructions arrive in program order, at most one per cycle. The arithmetic itself lives outside; each unit reports completion with a one-cycle done pulse. Operands are only ever read from the register file, so a consumer cannot start before its producer has written back.

Top module: `sb_scoreboard`

## Requirements
- R1: After reset every unit entry is free and every register is marked ready, so no issue, write or free strobe is raised and dispatch is not stalled while no instruction is offered.
- R2: The class code selects the unit: 0 integer (vector bit 0), 1 load (bit 1), 2 store (bit 2), 3 floating point, which takes bit 3 when that unit is free and bit 4 only otherwise. All per-unit output vectors use this bit order.
- R3: An offered instruction whose unit (both floating-point units for class 3) is occupied raises the dispatch stall for every such cycle and is not accepted; the stall is never raised without an offered instruction.
- R4: An offered instruction whose destination register already has a pending writer raises the dispatch stall until that writer has written back.
- R5: A unit raises its issue strobe for exactly one cycle, at the earliest in the cycle after dispatch, and only once neither source is waiting on a producer.
- R6: A unit writes back at the earliest in the cycle after its done pulse: the free strobe rises for that unit, and the register-write strobe rises with it unless the unit is the store unit, which writes no register.
- R7: A finished unit holds its write-back while another occupied unit that has not yet issued reads the destination register as a ready value; write-back follows in the cycle after that reader issues.
- R8: A unit waiting only on a producer may issue in the very cycle that producer writes back.
- R9: An instruction stalled on a busy unit or a pending writer is accepted in the very cycle that unit or writer writes back.
- R10: A done pulse for a unit that is free or has not yet issued has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | An instruction is offered this cycle |
| instClass | input | 2 | Unit class of the offered instruction (see R2) |
| instDst | input | 3 | Destination register (ignored for stores) |
| instSrcA | input | 3 | First source register |
| instSrcB | input | 3 | Second source register |
| doneVec | input | 5 | Per-unit completion pulse |
| dispatchStall | output | 1 | Offered instruction not accepted this cycle |
| issueVec | output | 5 | Per-unit operand read / start strobe |
| rfWriteVec | output | 5 | Per-unit register-file write enable |
| freeVec | output | 5 | Per-unit entry released this cycle |

## Verification
The bound checker watches, on every cycle, the local rules of each unit: issue only from an occupied entry and never twice in a row, write-back only from a completed entry, no register write without the entry being freed, completion only on a pulse, and no stall without an offered instruction. Whether the timing between units is right (RAW waiting, WAW and structural stalls, the WAR hold and its release, the same-cycle hand-offs, floating-point unit choice and ignored pulses) spans several units and cycles, so only the bench's directed scenarios, with exact expected cycles, can show it.

// File: rtl/sb_pkg.sv
package sb_pkg;
  parameter int NUM_UNITS = 5;
  parameter int NUM_REGS  = 8;
  localparam int REG_W = $clog2(NUM_REGS);
  localparam int TAG_W = $clog2(NUM_UNITS + 1);

  localparam int U_ALU   = 0;
  localparam int U_LOAD  = 1;
  localparam int U_STORE = 2;
  localparam int U_FP_A  = 3;
  localparam int U_FP_B  = 4;

  typedef enum logic [1:0] {
    CLS_ALU   = 2'd0,
    CLS_LOAD  = 2'd1,
    CLS_STORE = 2'd2,
    CLS_FP    = 2'd3
  } unit_class_e;

  // One row of the unit status table.
  typedef struct packed {
    logic              busy;
    logic              issued;
    logic              doneSeen;
    unit_class_e       cls;
    logic [REG_W-1:0]  dst;
    logic [REG_W-1:0]  srcA;
    logic [REG_W-1:0]  srcB;
    logic [TAG_W-1:0]  ownTag;
    logic [TAG_W-1:0]  tagA;
    logic [TAG_W-1:0]  tagB;
  } fu_entry_t;

  // Control to datapath update strobes.
  typedef struct packed {
    logic                 dispatchEn;
    logic [NUM_UNITS-1:0] dispatchSel;
    logic [TAG_W-1:0]     newTagA;
    logic [TAG_W-1:0]     newTagB;
    logic [NUM_UNITS-1:0] issueSel;
    logic [NUM_UNITS-1:0] doneSel;
    logic [NUM_UNITS-1:0] retireSel;
  } sb_strobe_t;

  function automatic logic classWrites(unit_class_e c);
    return c != CLS_STORE;
  endfunction
endpackage

// File: rtl/sb_datapath.sv
module sb_datapath
  import sb_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  sb_strobe_t                      strobes,
  input  unit_class_e                     instClass,
  input  logic [REG_W-1:0]                instDst,
  input  logic [REG_W-1:0]                instSrcA,
  input  logic [REG_W-1:0]                instSrcB,
  output fu_entry_t [NUM_UNITS-1:0]       fuTab,
  output logic [NUM_REGS-1:0][TAG_W-1:0]  regTag
);
  fu_entry_t [NUM_UNITS-1:0]       fuNext;
  logic [NUM_REGS-1:0][TAG_W-1:0]  regNext;

  always_comb begin
    fuNext  = fuTab;
    regNext = regTag;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (strobes.issueSel[u]) fuNext[u].issued   = 1'b1;
      if (strobes.doneSel[u])  fuNext[u].doneSeen = 1'b1;
    end
    // Write-back: release register tag, wake consumers, free entry.
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (strobes.retireSel[u]) begin
        if (classWrites(fuTab[u].cls) && regTag[fuTab[u].dst] == fuTab[u].ownTag)
          regNext[fuTab[u].dst] = '0;
        fuNext[u] = '0;
        for (int v = 0; v < NUM_UNITS; v++) begin
          if (fuTab[v].tagA == fuTab[u].ownTag) fuNext[v].tagA = '0;
          if (fuTab[v].tagB == fuTab[u].ownTag) fuNext[v].tagB = '0;
        end
      end
    end
    // Dispatch last so it may reuse an entry freed this cycle.
    if (strobes.dispatchEn) begin
      for (int u = 0; u < NUM_UNITS; u++) begin
        if (strobes.dispatchSel[u]) begin
          fuNext[u].busy     = 1'b1;
          fuNext[u].issued   = 1'b0;
          fuNext[u].doneSeen = 1'b0;
          fuNext[u].cls      = instClass;
          fuNext[u].dst      = instDst;
          fuNext[u].srcA     = instSrcA;
          fuNext[u].srcB     = instSrcB;
          fuNext[u].ownTag   = TAG_W'(u + 1);
          fuNext[u].tagA     = strobes.newTagA;
          fuNext[u].tagB     = strobes.newTagB;
          if (classWrites(instClass)) regNext[instDst] = TAG_W'(u + 1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fuTab  <= '0;
      regTag <= '0;
    end else begin
      fuTab  <= fuNext;
      regTag <= regNext;
    end
  end
endmodule

// File: rtl/sb_control.sv
module sb_control
  import sb_pkg::*;
(
  input  fu_entry_t [NUM_UNITS-1:0]       fuTab,
  input  logic [NUM_REGS-1:0][TAG_W-1:0]  regTag,
  input  logic                            instValid,
  input  unit_class_e                     instClass,
  input  logic [REG_W-1:0]                instDst,
  input  logic [REG_W-1:0]                instSrcA,
  input  logic [REG_W-1:0]                instSrcB,
  input  logic [NUM_UNITS-1:0]            doneVec,
  output sb_strobe_t                      strobes,
  output logic [NUM_UNITS-1:0]            rfWriteVec,
  output logic                            dispatchStall
);
  logic [NUM_UNITS-1:0] warHold, retire, unitAvail, sel, busyVec;
  logic wawBlock;

  // A tag counts as released when zero or when its unit writes back now.
  function automatic logic tagReleased(logic [TAG_W-1:0] t, logic [NUM_UNITS-1:0] ret);
    logic r;
    r = (t == '0);
    for (int u = 0; u < NUM_UNITS; u++)
      if (t == TAG_W'(u + 1) && ret[u]) r = 1'b1;
    return r;
  endfunction

  always_comb begin
    warHold = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      busyVec[u] = fuTab[u].busy;
      for (int v = 0; v < NUM_UNITS; v++) begin
        if (v != u && classWrites(fuTab[u].cls) && fuTab[v].busy && !fuTab[v].issued) begin
          if ((fuTab[v].srcA == fuTab[u].dst && fuTab[v].tagA != fuTab[u].ownTag) ||
              (fuTab[v].srcB == fuTab[u].dst && fuTab[v].tagB != fuTab[u].ownTag))
            warHold[u] = 1'b1;
        end
      end
      retire[u] = fuTab[u].busy && fuTab[u].doneSeen && !warHold[u];
    end
  end

  always_comb begin
    strobes = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      strobes.issueSel[u] = fuTab[u].busy && !fuTab[u].issued &&
                            tagReleased(fuTab[u].tagA, retire) &&
                            tagReleased(fuTab[u].tagB, retire);
      strobes.doneSel[u]  = doneVec[u] && fuTab[u].busy && fuTab[u].issued && !fuTab[u].doneSeen;
      rfWriteVec[u]       = retire[u] && classWrites(fuTab[u].cls);
    end
    strobes.retireSel = retire;

    unitAvail = ~busyVec | retire;
    sel = '0;
    unique case (instClass)
      CLS_ALU:   sel[U_ALU]   = unitAvail[U_ALU];
      CLS_LOAD:  sel[U_LOAD]  = unitAvail[U_LOAD];
      CLS_STORE: sel[U_STORE] = unitAvail[U_STORE];
      CLS_FP: begin
        if (unitAvail[U_FP_A])      sel[U_FP_A] = 1'b1;
        else if (unitAvail[U_FP_B]) sel[U_FP_B] = 1'b1;
      end
      default: sel = '0;
    endcase

    wawBlock = classWrites(instClass) && !tagReleased(regTag[instDst], retire);

    strobes.dispatchEn  = instValid && (|sel) && !wawBlock;
    strobes.dispatchSel = sel;
    strobes.newTagA = tagReleased(regTag[instSrcA], retire) ? '0 : regTag[instSrcA];
    strobes.newTagB = tagReleased(regTag[instSrcB], retire) ? '0 : regTag[instSrcB];
    dispatchStall = instValid && !strobes.dispatchEn;
  end
endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard
  import sb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  instValid,
  input  logic [1:0]            instClass,
  input  logic [REG_W-1:0]      instDst,
  input  logic [REG_W-1:0]      instSrcA,
  input  logic [REG_W-1:0]      instSrcB,
  input  logic [NUM_UNITS-1:0]  doneVec,
  output logic                  dispatchStall,
  output logic [NUM_UNITS-1:0]  issueVec,
  output logic [NUM_UNITS-1:0]  rfWriteVec,
  output logic [NUM_UNITS-1:0]  freeVec
);
  fu_entry_t [NUM_UNITS-1:0]       fuTab;
  logic [NUM_REGS-1:0][TAG_W-1:0]  regTag;
  sb_strobe_t                      strobes;
  logic [NUM_UNITS-1:0]            busyVec, doneSeenVec;

  sb_control ctrl_i (
    .fuTab(fuTab), .regTag(regTag), .instValid(instValid),
    .instClass(unit_class_e'(instClass)), .instDst(instDst),
    .instSrcA(instSrcA), .instSrcB(instSrcB), .doneVec(doneVec),
    .strobes(strobes), .rfWriteVec(rfWriteVec), .dispatchStall(dispatchStall)
  );

  sb_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .instClass(unit_class_e'(instClass)), .instDst(instDst),
    .instSrcA(instSrcA), .instSrcB(instSrcB),
    .fuTab(fuTab), .regTag(regTag)
  );

  assign issueVec = strobes.issueSel;
  assign freeVec  = strobes.retireSel;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_flags
    assign busyVec[u]     = fuTab[u].busy;
    assign doneSeenVec[u] = fuTab[u].doneSeen;
  end
endmodule

// File: rtl/sb_checker.sv
module sb_checker
  import sb_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  instValid,
  input logic                  dispatchStall,
  input logic [NUM_UNITS-1:0]  issueVec,
  input logic [NUM_UNITS-1:0]  rfWriteVec,
  input logic [NUM_UNITS-1:0]  freeVec,
  input logic [NUM_UNITS-1:0]  doneVec,
  input logic [NUM_UNITS-1:0]  busyVec,
  input logic [NUM_UNITS-1:0]  doneSeenVec
);
  assert_stall_needs_inst_R3: assert property (@(posedge clk) disable iff (!rstN)
    dispatchStall |-> instValid);

  assert_write_implies_free_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rfWriteVec & ~freeVec) == '0);

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assert_issue_from_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
      issueVec[u] |-> busyVec[u]);

    assert_issue_single_R5: assert property (@(posedge clk) disable iff (!rstN)
      issueVec[u] |=> !issueVec[u]);

    assert_free_after_done_R6: assert property (@(posedge clk) disable iff (!rstN)
      freeVec[u] |-> doneSeenVec[u]);

    assert_no_issue_on_free_R7: assert property (@(posedge clk) disable iff (!rstN)
      freeVec[u] |-> !issueVec[u]);

    assert_done_from_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
      $rose(doneSeenVec[u]) |-> $past(doneVec[u]));
  end
endmodule

bind sb_scoreboard sb_checker chk_i (
  .clk(clk), .rstN(rstN), .instValid(instValid), .dispatchStall(dispatchStall),
  .issueVec(issueVec), .rfWriteVec(rfWriteVec), .freeVec(freeVec),
  .doneVec(doneVec), .busyVec(busyVec), .doneSeenVec(doneSeenVec)
);

// File: tb/sb_scoreboard_tb_top.sv
module sb_scoreboard_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN;
  logic       instValid;
  logic [1:0] instClass;
  logic [2:0] instDst, instSrcA, instSrcB;
  logic [4:0] doneVec;
  logic       dispatchStall;
  logic [4:0] issueVec, rfWriteVec, freeVec;

  sb_scoreboard dut_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instClass(instClass),
    .instDst(instDst), .instSrcA(instSrcA), .instSrcB(instSrcB),
    .doneVec(doneVec), .dispatchStall(dispatchStall), .issueVec(issueVec),
    .rfWriteVec(rfWriteVec), .freeVec(freeVec)
  );

  typedef struct {
    int         cyc;
    logic [4:0] iss;
    logic [4:0] wr;
    logic [4:0] fr;
    logic       st;
    string      req;
  } exp_t;

  exp_t expQ[$];
  int total = 0;
  int bad = 0;
  int cyc = 0;
  int base = 0;
  logic running = 1'b0;
  logic finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expectAt(int off, logic [4:0] iss, logic [4:0] wr, logic [4:0] fr,
                          logic st, string req);
    exp_t e;
    e.cyc = base + off; e.iss = iss; e.wr = wr; e.fr = fr; e.st = st; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic drv(logic v, logic [1:0] c, int d, int a, int b, logic [4:0] dn);
    instValid = v; instClass = c;
    instDst = 3'(d); instSrcA = 3'(a); instSrcB = 3'(b);
    doneVec = dn;
    @(posedge clk); #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drv(1'b0, 2'd0, 0, 0, 0, 5'b0);
  endtask

  // Monitor: compares each active cycle against the expected queue.
  always @(negedge clk) begin
    if (running) begin
      logic active;
      active = (|issueVec) || (|rfWriteVec) || (|freeVec) || dispatchStall;
      if (expQ.size() > 0 && expQ[0].cyc == cyc) begin
        exp_t e;
        e = expQ.pop_front();
        total++;
        if (issueVec !== e.iss || rfWriteVec !== e.wr || freeVec !== e.fr ||
            dispatchStall !== e.st) begin
          bad++;
          $display("FAIL %s cyc=%0d actual iss=%b wr=%b free=%b stall=%b expected iss=%b wr=%b free=%b stall=%b",
                   e.req, cyc, issueVec, rfWriteVec, freeVec, dispatchStall,
                   e.iss, e.wr, e.fr, e.st);
        end
      end else if (active) begin
        total++;
        bad++;
        $display("FAIL unexpected activity (R3/R5/R6/R7/R10) cyc=%0d actual iss=%b wr=%b free=%b stall=%b expected all zero",
                 cyc, issueVec, rfWriteVec, freeVec, dispatchStall);
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog expired, actual running expected finished");
    finish();
  end

  initial begin
    rstN = 1'b0;
    instValid = 1'b0; instClass = 2'd0; instDst = '0; instSrcA = '0; instSrcB = '0;
    doneVec = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1: reset state, nothing pending
    total++;
    if (issueVec !== 5'b0 || rfWriteVec !== 5'b0 || freeVec !== 5'b0 || dispatchStall !== 1'b0) begin
      bad++;
      $display("FAIL R1 actual iss=%b wr=%b free=%b stall=%b expected all zero",
               issueVec, rfWriteVec, freeVec, dispatchStall);
    end
    @(posedge clk); #1;
    running = 1'b1;

    // Scenario A: load feeds FP; RAW wait and same-cycle issue (R5, R8)
    base = cyc;
    expectAt(1, 5'b00010, 5'b0, 5'b0, 1'b0, "R5");
    expectAt(3, 5'b01000, 5'b00010, 5'b00010, 1'b0, "R8");
    expectAt(5, 5'b0, 5'b01000, 5'b01000, 1'b0, "R6");
    drv(1'b1, 2'd1, 1, 2, 2, 5'b0);
    drv(1'b1, 2'd3, 3, 1, 4, 5'b0);
    drv(1'b0, 2'd0, 0, 0, 0, 5'b00010);
    idle(1);
    drv(1'b0, 2'd0, 0, 0, 0, 5'b01000);
    idle(3);

    // Scenario B: structural stalls, FP unit choice (R2, R3, R9)
    base = cyc;
    expectAt(1,  5'b00001, 5'b0, 5'b0, 1'b1, "R3");
    expectAt(2,  5'b0, 5'b0, 5'b0, 1'b1, "R3");
    expectAt(3,  5'b0, 5'b00001, 5'b00001, 1'b0, "R9");
    expectAt(4,  5'b00001, 5'b0, 5'b0, 1'b0, "R5");
    expectAt(5,  5'b01000, 5'b0, 5'b0, 1'b0, "R2");
    expectAt(6,  5'b10000, 5'b00001, 5'b00001, 1'b1, "R2");
    expectAt(7,  5'b0, 5'b0, 5'b0, 1'b1, "R3");
    expectAt(8,  5'b0, 5'b11000, 5'b11000, 1'b0, "R9");
    expectAt(9,  5'b01000, 5'b0, 5'b0, 1'b0, "R2");
    expectAt(11, 5'b0, 5'b01000, 5'b01000, 1'b0, "R6");
    drv(1'b1, 2'd0, 5, 6, 6, 5'b0);
    drv(1'b1, 2'd0, 7, 6, 6, 5'b0);
    drv(1'b1, 2'd0, 7, 6, 6, 5'b00001);
    drv(1'b1, 2'd0, 7, 6, 6, 5'b0);
    drv(1'b1, 2'd3, 1, 2, 2, 5'b0);
    drv(1'b1, 2'd3, 2, 3, 3, 5'b00001);
    drv(1'b1, 2'd3, 3, 4, 4, 5'b0);
    drv(1'b1, 2'd3, 3, 4, 4, 5'b11000);
    drv(1'b1, 2'd3, 3, 4, 4, 5'b0);
    idle(1);
    drv(1'b0, 2'd0, 0, 0, 0, 5'b01000);
    idle(3);

    // Scenario C: WAW stall released by write-back (R4, R9)
    base = cyc;
    expectAt(1, 5'b00010, 5'b0, 5'b0, 1'b1, "R4");
    expectAt(2, 5'b0, 5'b0, 5'b0, 1'b1, "R4");
    expectAt(3, 5'b0, 5'b00010, 5'b00010, 1'b0, "R9");
    expectAt(4, 5'b00001, 5'b0, 5'b0, 1'b0, "R5");
    expectAt(6, 5'b0, 5'b00001, 5'b00001, 1'b0, "R6");
    drv(1'b1, 2'd1, 1, 2, 2, 5'b0);
    drv(1'b1, 2'd0, 1, 3, 3, 5'b0);
    drv(1'b1, 2'd0, 1, 3, 3, 5'b00010);
    drv(1'b1, 2'd0, 1, 3, 3, 5'b0);
    idle(1);
    drv(1'b0, 2'd0, 0, 0, 0, 5'b00001);
    idle(3);

    // Scenario D: WAR hold until older reader issues (R7, R8)
    base = cyc;
    expectAt(1,  5'b00010, 5'b0, 5'b0, 1'b0, "R5");
    expectAt(3,  5'b00001, 5'b0, 5'b0, 1'b0, "R5");
    expectAt(7,  5'b01000, 5'b00010, 5'b00010, 1'b0, "R8");
    expectAt(8,  5'b0, 5'b00001, 5'b00001, 1'b0, "R7");
    expectAt(10, 5'b0, 5'b01000, 5'b01000, 1'b0, "R6");
    drv(1'b1, 2'd1, 4, 5, 5, 5'b0);
    drv(1'b1, 2'd3, 6, 4, 2, 5'b0);
    drv(1'b1, 2'd0, 2, 3, 3, 5'b0);
    idle(1);
    drv(1'b0, 2'd0, 0, 0, 0, 5'b00001);
    idle(1);
    drv(1'b0, 2'd0, 0, 0, 0, 5'b00010);
    idle(2);
    drv(1'b0, 2'd0, 0, 0, 0, 5'b01000);
    idle(3);

    // Scenario E: store frees without write; stray done ignored (R6, R10)
    base = cyc;
    expectAt(1, 5'b00100, 5'b0, 5'b0, 1'b0, "R5");
    expectAt(2, 5'b00001, 5'b0, 5'b0, 1'b0, "R10");
    expectAt(3, 5'b0, 5'b0, 5'b00100, 1'b0, "R6");
    expectAt(6, 5'b0, 5'b00001, 5'b00001, 1'b0, "R10");
    drv(1'b1, 2'd2, 0, 1, 2, 5'b00001);
    drv(1'b1, 2'd0, 3, 1, 1, 5'b0);
    drv(1'b0, 2'd0, 0, 0, 0, 5'b00100);
    idle(2);
    drv(1'b0, 2'd0, 0, 0, 0, 5'b00001);
    idle(4);

    running = 1'b0;
    while (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      total++;
      bad++;
      $display("FAIL %s cyc=%0d actual no match expected iss=%b wr=%b free=%b stall=%b",
               e.req, e.cyc, e.iss, e.wr, e.fr, e.st);
    end
    finish();
  end
endmodule